// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit

This block is the arithmetic core of a byte-wide accumulator processor. Each cycle, the fetch logic may present an operation code together with the accumulator, a second operand, the B register, the 16-bit data pointer and the current carry, auxiliary-carry and overflow flags. The fetch logic has already resolved the second operand from a register, a direct or indirect location, or an immediate. One clock later the unit returns a primary result byte and a secondary result byte, along with an updated pointer and the three flags. The sequencer writes these back to wherever the instruction names.

The operations are add, add with carry, subtract with borrow, byte increment and decrement, pointer increment and decrement, multiply, divide, packed-BCD decimal adjust, and bitwise AND and OR. Subtraction always consumes the incoming carry as a borrow. Multiply returns a double-width product split over two bytes. Divide returns the quotient and the remainder separately.

Top module: `acc_alu`

## Requirements
- R1: Reset clears `out_valid`, both result bytes, the pointer output and all three flags. Every accepted request (`in_valid` high at a rising edge) produces exactly one result with `out_valid` high after that same edge. `out_valid` is low after an edge with `in_valid` low.
- R2: Op 0 (add) returns `acc+opnd` and op 1 (add with carry) returns `acc+opnd+cy_in`, both modulo 256. Carry is the carry out of bit 7, auxiliary carry is the carry out of bit 3, and overflow flags a two's-complement result outside -128..127.
- R3: Op 2 returns `acc-opnd-cy_in` modulo 256. Carry is set when a borrow is needed, auxiliary carry when the low nibbles need a borrow, and overflow on signed overflow.
- R4: Op 5 returns the low byte of `acc*breg` on `res_lo` and the high byte on `res_hi`. Carry is cleared, overflow is set exactly when the product exceeds 255, and auxiliary carry is unchanged.
- R5: Op 6 with a nonzero `breg` returns `acc/breg` on `res_lo` and `acc mod breg` on `res_hi`. Carry and overflow are cleared and auxiliary carry is unchanged.
- R6: Op 6 with `breg` zero sets overflow and clears carry; the result bytes are then unspecified.
- R7: Op 7 (decimal adjust of `acc`) works in two steps. It first adds 6 if the low nibble exceeds 9 or `ac_in` is set. It then adds 0x60 if, after that first step, the high nibble exceeds 9, `cy_in` is set, or the first step carried out of bit 7. Carry is set if `cy_in` was set or either step carried out of bit 7, so it is never cleared. Auxiliary carry and overflow are unchanged.
- R8: Op 3 returns `opnd+1` and op 4 returns `opnd-1`, both wrapping modulo 256, and leave all three flags unchanged.
- R9: Op 8 returns `acc & opnd` and op 9 returns `acc | opnd`, with all three flags unchanged.
- R10: Op 10 returns `ptr+1` and op 11 returns `ptr-1` on `ptr_out`, both wrapping modulo 65536. For these ops `res_lo` equals `acc` and all flags are unchanged.
- R11: `res_hi` equals `breg` for every op other than 5 and 6, and `ptr_out` equals `ptr` for every op other than 10 and 11. Op codes 12 to 15 return `acc` on `res_lo` with all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| op | input | 4 | Operation code |
| acc | input | DW | Accumulator value |
| opnd | input | DW | Second operand, already fetched |
| breg | input | DW | B register value |
| cy_in | input | 1 | Current carry flag |
| ac_in | input | 1 | Current auxiliary carry flag |
| ov_in | input | 1 | Current overflow flag |
| ptr | input | PW | Current data pointer |
| out_valid | output | 1 | Result present |
| res_lo | output | DW | Primary result (accumulator destination) |
| res_hi | output | DW | Secondary result (B destination) |
| ptr_out | output | PW | Updated data pointer |
| cy_out | output | 1 | New carry flag |
| ac_out | output | 1 | New auxiliary carry flag |
| ov_out | output | 1 | New overflow flag |

## Verification
The bench builds the unit with its default widths: an 8-bit datapath and a 16-bit pointer. At these sizes every one of the 65,536 operand pairs can be pushed through multiply and divide, which covers each restoring-divider path and the divide-by-zero row completely. The same sizes make the pointer wrap at 0xFFFF and 0x0000 and all 256 decimal-adjust inputs under each flag combination cheap to reach. Add, add with carry and subtract are swept on a dense operand grid with random incoming flags, so carry, nibble-carry and signed-overflow edges are all hit.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int DW = 8,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [3:0]    op,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] opnd,
  input  logic [DW-1:0] breg,
  input  logic          cy_in,
  input  logic          ac_in,
  input  logic          ov_in,
  input  logic [PW-1:0] ptr,
  output logic          out_valid,
  output logic [DW-1:0] res_lo,
  output logic [DW-1:0] res_hi,
  output logic [PW-1:0] ptr_out,
  output logic          cy_out,
  output logic          ac_out,
  output logic          ov_out
);
  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_ADDC = 4'd1;
  localparam logic [3:0] OP_SUBB = 4'd2;
  localparam logic [3:0] OP_INC  = 4'd3;
  localparam logic [3:0] OP_DEC  = 4'd4;
  localparam logic [3:0] OP_MUL  = 4'd5;
  localparam logic [3:0] OP_DIV  = 4'd6;
  localparam logic [3:0] OP_DA   = 4'd7;
  localparam logic [3:0] OP_AND  = 4'd8;
  localparam logic [3:0] OP_OR   = 4'd9;
  localparam logic [3:0] OP_PINC = 4'd10;
  localparam logic [3:0] OP_PDEC = 4'd11;
  localparam int NB = 4;
  localparam int MSB = DW - 1;

  // R2: add paths
  logic          add_cin;
  logic [DW:0]   sum_w;
  logic          add_ac, add_ov;
  assign add_cin = (op == OP_ADDC) & cy_in;
  assign sum_w   = {1'b0, acc} + {1'b0, opnd} + {{DW{1'b0}}, add_cin};
  assign add_ac  = ({1'b0, acc[NB-1:0]} + {1'b0, opnd[NB-1:0]} + {{NB{1'b0}}, add_cin}) > {1'b0, {NB{1'b1}}};
  assign add_ov  = (acc[MSB] == opnd[MSB]) && (sum_w[MSB] != acc[MSB]);

  // R3: subtract with borrow
  logic [DW:0]   dif_w;
  logic          sub_ac, sub_ov;
  assign dif_w  = {1'b0, acc} - {1'b0, opnd} - {{DW{1'b0}}, cy_in};
  assign sub_ac = {1'b0, acc[NB-1:0]} < ({1'b0, opnd[NB-1:0]} + {{NB{1'b0}}, cy_in});
  assign sub_ov = (acc[MSB] != opnd[MSB]) && (dif_w[MSB] != acc[MSB]);

  // R4: multiply
  logic [2*DW-1:0] prod;
  assign prod = {{DW{1'b0}}, acc} * {{DW{1'b0}}, breg};

  // R5 R6: restoring divider, one stage per quotient bit
  logic [DW-1:0] part [0:DW];
  logic [DW-1:0] quo;
  assign part[0] = '0;
  for (genvar k = 0; k < DW; k++) begin : g_div
    logic [DW:0] sh;
    assign sh          = {part[k], acc[DW-1-k]};
    assign quo[DW-1-k] = sh >= {1'b0, breg};
    assign part[k+1]   = DW'(quo[DW-1-k] ? sh - {1'b0, breg} : sh);
  end

  // R7: decimal adjust
  logic          lo_fix, hi_fix;
  logic [DW:0]   da1, da2;
  assign lo_fix = (acc[NB-1:0] > NB'(9)) | ac_in;
  assign da1    = {1'b0, acc} + (lo_fix ? (DW+1)'(6) : '0);
  assign hi_fix = (da1[DW-1:NB] > (DW-NB)'(9)) | cy_in | da1[DW];
  assign da2    = da1 + (hi_fix ? (DW+1)'(6 << NB) : '0);

  logic [DW-1:0] n_lo, n_hi;
  logic [PW-1:0] n_ptr;
  logic          n_cy, n_ac, n_ov;

  always_comb begin
    n_lo  = acc;
    n_hi  = breg;
    n_ptr = ptr;
    n_cy  = cy_in;
    n_ac  = ac_in;
    n_ov  = ov_in;
    case (op)
      OP_ADD, OP_ADDC: begin
        n_lo = sum_w[DW-1:0]; n_cy = sum_w[DW]; n_ac = add_ac; n_ov = add_ov;
      end
      OP_SUBB: begin
        n_lo = dif_w[DW-1:0]; n_cy = dif_w[DW]; n_ac = sub_ac; n_ov = sub_ov;
      end
      OP_INC:  n_lo = opnd + DW'(1);
      OP_DEC:  n_lo = opnd - DW'(1);
      OP_MUL: begin
        n_lo = prod[DW-1:0]; n_hi = prod[2*DW-1:DW];
        n_cy = 1'b0; n_ov = |prod[2*DW-1:DW];
      end
      OP_DIV: begin
        n_lo = quo; n_hi = part[DW];
        n_cy = 1'b0; n_ov = ~|breg;
      end
      OP_DA: begin
        n_lo = da2[DW-1:0]; n_cy = cy_in | da1[DW] | da2[DW];
      end
      OP_AND:  n_lo = acc & opnd;
      OP_OR:   n_lo = acc | opnd;
      OP_PINC: n_ptr = ptr + PW'(1);
      OP_PDEC: n_ptr = ptr - PW'(1);
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_lo    <= '0;
      res_hi    <= '0;
      ptr_out   <= '0;
      cy_out    <= 1'b0;
      ac_out    <= 1'b0;
      ov_out    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res_lo  <= n_lo;
        res_hi  <= n_hi;
        ptr_out <= n_ptr;
        cy_out  <= n_cy;
        ac_out  <= n_ac;
        ov_out  <= n_ov;
      end
    end
  end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int DW = 8,
  parameter int PW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [3:0]    op,
  input logic [DW-1:0] breg,
  input logic          cy_in,
  input logic [PW-1:0] ptr,
  input logic          out_valid,
  input logic [DW-1:0] res_hi,
  input logic [PW-1:0] ptr_out,
  input logic          cy_out,
  input logic          ov_out
);
  AST_ACCEPT_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R1
  AST_MUL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd5) |=> (!cy_out && (ov_out == (res_hi != '0)))); // R4
  AST_DIV_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd6 && breg != '0) |=> (res_hi < $past(breg) && !ov_out && !cy_out)); // R5
  AST_DIV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd6 && breg == '0) |=> (ov_out && !cy_out)); // R6
  AST_DA_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd7 && cy_in) |=> cy_out); // R7
  AST_INCDEC_CY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == 4'd3 || op == 4'd4)) |=> (cy_out == $past(cy_in))); // R8
  AST_LOGIC_CY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == 4'd8 || op == 4'd9)) |=> (cy_out == $past(cy_in))); // R9
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd10) |=> (ptr_out == $past(ptr) + PW'(1))); // R10
endmodule

bind acc_alu acc_alu_chk #(.DW(DW), .PW(PW)) i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .breg(breg),
  .cy_in(cy_in), .ptr(ptr), .out_valid(out_valid), .res_hi(res_hi),
  .ptr_out(ptr_out), .cy_out(cy_out), .ov_out(ov_out)
);

// File: tb/test_acc_alu.sv
`timescale 1ns/1ps
module test_acc_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  op = '0;
  logic [7:0]  acc = '0, opnd = '0, breg = '0;
  logic        cy_in = 1'b0, ac_in = 1'b0, ov_in = 1'b0;
  logic [15:0] ptr = '0;
  logic        out_valid;
  logic [7:0]  res_lo, res_hi;
  logic [15:0] ptr_out;
  logic        cy_out, ac_out, ov_out;

  int ntests = 0;
  int nfail  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  acc_alu i_acc_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .acc(acc),
    .opnd(opnd), .breg(breg), .cy_in(cy_in), .ac_in(ac_in), .ov_in(ov_in),
    .ptr(ptr), .out_valid(out_valid), .res_lo(res_lo), .res_hi(res_hi),
    .ptr_out(ptr_out), .cy_out(cy_out), .ac_out(ac_out), .ov_out(ov_out)
  );

  typedef struct packed {
    logic [7:0]  lo;
    logic [7:0]  hi;
    logic [15:0] ptr;
    logic        cy, ac, ov, full;
    int          req;
  } exp_t;

  exp_t sb[$];

  function automatic int sgn(int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic exp_t model(int o, int a, int b, int bb, int c, int acx, int ovx, int p);
    exp_t e;
    int s, v;
    e.lo = 8'(a); e.hi = 8'(bb); e.ptr = 16'(p);
    e.cy = c[0]; e.ac = acx[0]; e.ov = ovx[0]; e.full = 1'b1; e.req = 11; // R11
    case (o)
      0, 1: begin // R2
        v = (o == 1) ? c : 0;
        s = a + b + v;
        e.lo = 8'(s); e.cy = s > 255; e.ac = (a % 16 + b % 16 + v) > 15;
        s = sgn(a) + sgn(b) + v; e.ov = (s > 127) || (s < -128); e.req = 2;
      end
      2: begin // R3
        s = a - b - c;
        e.lo = 8'(s); e.cy = s < 0; e.ac = (a % 16 - b % 16 - c) < 0;
        s = sgn(a) - sgn(b) - c; e.ov = (s > 127) || (s < -128); e.req = 3;
      end
      3: begin e.lo = 8'((b + 1) % 256);   e.req = 8; end // R8
      4: begin e.lo = 8'((b + 255) % 256); e.req = 8; end
      5: begin // R4
        s = a * bb; e.lo = 8'(s % 256); e.hi = 8'(s / 256);
        e.cy = 1'b0; e.ov = s > 255; e.req = 4;
      end
      6: begin
        e.cy = 1'b0;
        if (bb == 0) begin e.ov = 1'b1; e.full = 1'b0; e.req = 6; end // R6
        else begin e.lo = 8'(a / bb); e.hi = 8'(a % bb); e.ov = 1'b0; e.req = 5; end // R5
      end
      7: begin // R7
        v = a;
        if ((v % 16) > 9 || acx != 0) v = v + 6;
        if (((v / 16) % 16) > 9 || c != 0 || v > 255) v = v + 96;
        e.lo = 8'(v % 256); e.cy = (c != 0) || (v > 255); e.req = 7;
      end
      8: begin e.lo = 8'(a & b); e.req = 9; end // R9
      9: begin e.lo = 8'(a | b); e.req = 9; end
      10: begin e.ptr = 16'((p + 1) % 65536);     e.req = 10; end // R10
      11: begin e.ptr = 16'((p + 65535) % 65536); e.req = 10; end
      default: ;
    endcase
    return e;
  endfunction

  task automatic send(int o, int a, int b, int bb, int c, int acx, int ovx, int p);
    @(negedge clk);
    in_valid = 1'b1; op = 4'(o); acc = 8'(a); opnd = 8'(b); breg = 8'(bb);
    cy_in = c[0]; ac_in = acx[0]; ov_in = ovx[0]; ptr = 16'(p);
    sb.push_back(model(o, a, b, bb, c, acx, ovx, p));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    exp_t e;
    if (rst_n && out_valid) begin
      ntests++;
      if (sb.size() == 0) begin
        nfail++;
        $display("FAIL R1 unexpected result: lo=%0h expected no result", res_lo);
      end else begin
        e = sb.pop_front();
        if ((e.full && (res_lo !== e.lo || res_hi !== e.hi)) || ptr_out !== e.ptr ||
            cy_out !== e.cy || ac_out !== e.ac || ov_out !== e.ov) begin
          nfail++;
          $display("FAIL R%0d op=%0d a=%0h b=%0h bb=%0h: got lo=%0h hi=%0h ptr=%0h cy=%0b ac=%0b ov=%0b expected lo=%0h hi=%0h ptr=%0h cy=%0b ac=%0b ov=%0b",
                   e.req, op, acc, opnd, breg, res_lo, res_hi, ptr_out, cy_out, ac_out, ov_out,
                   e.lo, e.hi, e.ptr, e.cy, e.ac, e.ov);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    ntests++; // R1 reset state
    if (out_valid !== 1'b0 || res_lo !== 8'h00 || res_hi !== 8'h00 || ptr_out !== 16'h0 ||
        cy_out !== 1'b0 || ac_out !== 1'b0 || ov_out !== 1'b0) begin
      nfail++;
      $display("FAIL R1 reset: got v=%0b lo=%0h hi=%0h ptr=%0h flags=%0b%0b%0b expected all zero",
               out_valid, res_lo, res_hi, ptr_out, cy_out, ac_out, ov_out);
    end
    rst_n = 1'b1;

    // R2 R3: add, add with carry, subtract with borrow over a grid
    for (int a = 0; a < 256; a += 5)
      for (int b = 0; b < 256; b += 3)
        for (int o = 0; o < 3; o++)
          send(o, a, b, $urandom % 256, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 65536);
    send(0, 8'h7F, 8'h01, 0, 1, 0, 0, 0);
    send(1, 8'hFF, 8'h00, 0, 1, 0, 0, 0);
    send(2, 8'h80, 8'h00, 0, 1, 0, 0, 0);
    send(2, 8'h00, 8'hFF, 0, 1, 0, 0, 0);

    // R4 R5 R6: every operand pair for multiply and divide
    for (int a = 0; a < 256; a++)
      for (int bb = 0; bb < 256; bb++) begin
        send(5, a, $urandom % 256, bb, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 65536);
        send(6, a, $urandom % 256, bb, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 65536);
      end

    // R7: every accumulator value under all carry and nibble-carry combinations
    for (int a = 0; a < 256; a++)
      for (int f = 0; f < 4; f++)
        send(7, a, 0, $urandom % 256, f / 2, f % 2, $urandom % 2, 0);

    // R8 R9: byte step and logic keep all flags
    for (int b = 0; b < 256; b++) begin
      send(3, $urandom % 256, b, 0, $urandom % 2, $urandom % 2, $urandom % 2, 0);
      send(4, $urandom % 256, b, 0, $urandom % 2, $urandom % 2, $urandom % 2, 0);
      send(8, $urandom % 256, b, 0, $urandom % 2, $urandom % 2, $urandom % 2, 0);
      send(9, $urandom % 256, b, 0, $urandom % 2, $urandom % 2, $urandom % 2, 0);
    end

    // R10: pointer step including wrap points
    send(10, 8'h5A, 0, 8'h11, 1, 1, 1, 16'hFFFF);
    send(11, 8'hA5, 0, 8'h22, 0, 1, 0, 16'h0000);
    send(10, 8'h01, 0, 8'h33, 1, 0, 1, 16'h00FF);
    send(11, 8'h02, 0, 8'h44, 0, 0, 1, 16'h0100);
    for (int i = 0; i < 64; i++)
      send(10 + (i % 2), $urandom % 256, 0, $urandom % 256, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 65536);

    // R11: unused op codes pass the accumulator and flags through
    for (int o = 12; o < 16; o++)
      for (int i = 0; i < 8; i++)
        send(o, $urandom % 256, $urandom % 256, $urandom % 256, $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 65536);

    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    ntests++; // R1 every request answered, nothing after idle
    if (sb.size() != 0 || out_valid !== 1'b0) begin
      nfail++;
      $display("FAIL R1 drain: got %0d pending, valid=%0b expected 0 pending, valid=0", sb.size(), out_valid);
    end
    finish_run();
  end
endmodule